// File: doc/BRIEF.md
# Wire Hit Time-Bin Encoder

This block turns the discriminated hit pulses of one drift-chamber cell into a compact per-crossing bin map. A crossing strobe restarts an internal fine-time counter and clears all hit flags. Each bin has its own start and stop, programmed in counter ticks. A wire whose pulse is high inside the open interval of a bin gets that bin's flag. Once the last active bin has closed, the whole cell word is presented for one cycle with a valid pulse.

Real pulses are longer than one bin, so most hits also reach into the next bin. To suppress that overlap, the block applies a programmable "not sure" head at the start of every bin except the first. A hit that falls only inside that head does not flag the bin when the same wire already flagged the bin before it. A mode input selects full resolution (six bins per wire) or a compatibility mode with two bins per wire. The mode is sampled at each crossing strobe.

Top module: `wire_tbin_encoder`

## Requirements
- R1: After reset, `valid_o` is 0 and `word_o` is all zeros.
- R2: In six-bin mode, a wire `w` that is high while the fine count `t` (ticks since the crossing strobe, the strobe cycle counting as the tick before 0) satisfies start_b <= t < stop_b sets bit `w*6+b` of the next presented word.
- R3: A hit at a fine count that lies outside every bin window sets no bit.
- R4: For bin b >= 1, a hit with start_b <= t < start_b + nsure_len does not set bit b when the same wire's flag for bin b-1 is already set. A hit later in the bin, or one on a wire without a flag in bin b-1, still sets bit b.
- R5: With `nsure_len_i` = 0, no hit is suppressed, and a pulse spanning two bins sets both bits.
- R6: All flags are cleared by each crossing strobe. A word never contains hits from an earlier crossing.
- R7: `valid_o` goes high for exactly one cycle per crossing. This is the cycle after the fine count equals the stop of the last active bin (bin 5 in six-bin mode, bin 1 in two-bin mode). It is low before that cycle and after it.
- R8: In two-bin mode (`legacy_i` = 1 at the strobe), bin 0 and bin 1 use the first two programmed windows. A hit sets bit `w*2+b`, and bits 71..24 are zero.
- R9: The not-sure suppression of R4 also applies between bin 0 and bin 1 in two-bin mode.
- R10: Bin windows are taken from `bin_start_i`/`bin_stop_i` (bin b in bits b*8 +: 8). Moving a window moves which fine counts flag that bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_i | input | 1 | Crossing strobe, one cycle; restarts the fine count and clears flags |
| wire_i | input | 12 | Discriminated wire pulses, synchronous to clk |
| legacy_i | input | 1 | 1 selects two-bin mode, sampled at the strobe |
| bin_start_i | input | 48 | Start tick per bin, bin b at bits b*8 +: 8 |
| bin_stop_i | input | 48 | Stop tick (exclusive) per bin, bin b at bits b*8 +: 8 |
| nsure_len_i | input | 8 | Length in ticks of the not-sure head of bins 1..5 |
| word_o | output | 72 | Cell bin word, held between valid pulses |
| valid_o | output | 1 | One-cycle pulse when a new word is presented |

## Verification
Every cycle, assertions check the following. Flags stay set within a crossing and are cleared at every strobe. An in-window hit that is not suppressed sets its flag, while a suppressed head hit leaves the flag clear. The counter restarts at zero after a strobe. The valid pulse is a single cycle and comes only after the count reaches the last active stop. In two-bin mode the upper word bits stay zero.

Some behaviours can only be shown by the bench's scenarios, because they need a known hit pattern and hand-worked expected words. These are the bit placement of each wire and bin, gaps between moved windows, the contrast between a zero and a non-zero not-sure head, carry-over between crossings, and packing and suppression in two-bin mode.

// File: rtl/tbin_pkg.sv
package tbin_pkg;
  localparam int TBIN_CNT_W  = 8;
  localparam int TBIN_NBINS  = 6;
  localparam int TBIN_NWIRES = 12;
  localparam int TBIN_LEGACY_BINS = 2;

  // half-open interval test: lo <= t < hi
  function automatic logic f_in_span(input logic [15:0] t,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (t >= lo) && (t < hi);
  endfunction

  // head of a bin: start <= t < start + len, computed without wrap
  function automatic logic f_in_head(input logic [15:0] t,
                                     input logic [15:0] start,
                                     input logic [15:0] len);
    logic [16:0] t_x, s_x, e_x;
    t_x = {1'b0, t};
    s_x = {1'b0, start};
    e_x = s_x + {1'b0, len};
    return (t_x >= s_x) && (t_x < e_x);
  endfunction

  // bit position of a wire/bin flag in the packed cell word
  function automatic int f_bitpos(input int wire_idx, input int bin_idx,
                                  input int bins_per_wire);
    return wire_idx * bins_per_wire + bin_idx;
  endfunction
endpackage

// File: rtl/tbin_timer.sv
module tbin_timer #(
  parameter int CNT_W = tbin_pkg::TBIN_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!at_max) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R6: the fine count restarts at every crossing strobe
  a_r6_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

  // R7: the count advances monotonically until saturation
  a_r7_timer_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !at_max) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/tbin_wire.sv
module tbin_wire #(
  parameter int NBINS = tbin_pkg::TBIN_NBINS,
  parameter int CNT_W = tbin_pkg::TBIN_CNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   hit_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [NBINS*CNT_W-1:0] start_i,
  input  logic [NBINS*CNT_W-1:0] stop_i,
  input  logic [CNT_W-1:0]       nsure_i,
  output logic [NBINS-1:0]       flags_o
);
  import tbin_pkg::*;

  logic [NBINS-1:0] flag_q;
  logic [NBINS-1:0] win_hit;   // hit lies inside bin window
  logic [NBINS-1:0] ns_blk;    // hit falls in not-sure head after a flagged bin
  logic [NBINS-1:0] set_ev;    // flag is being set this cycle

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    logic fq;
    logic [CNT_W-1:0] b_start, b_stop;

    assign b_start = start_i[b*CNT_W +: CNT_W];
    assign b_stop  = stop_i[b*CNT_W +: CNT_W];

    assign win_hit[b] = hit_i &&
                        f_in_span(16'(cnt_i), 16'(b_start), 16'(b_stop));

    if (b == 0) begin : g_first
      assign ns_blk[b] = 1'b0;
    end else begin : g_rest
      assign ns_blk[b] = flag_q[b-1] &&
                         f_in_head(16'(cnt_i), 16'(b_start), 16'(nsure_i));
    end

    assign set_ev[b] = win_hit[b] && !ns_blk[b];

    always_ff @(posedge clk) begin
      if (!rst_n)      fq <= 1'b0;
      else if (clr_i)  fq <= 1'b0;
      else if (set_ev[b]) fq <= 1'b1;
    end

    assign flag_q[b] = fq;

    // R2: an accepted in-window hit sets the flag
    a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && win_hit[b] && !ns_blk[b]) |=> flag_q[b]);

    // R2: a flag stays set for the rest of the crossing
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && flag_q[b]) |=> flag_q[b]);

    // R4: a suppressed head hit leaves a clear flag clear
    a_r4_head_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !flag_q[b] && ns_blk[b]) |=> !flag_q[b]);

    // R6: the strobe clears every flag
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !flag_q[b]);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/tbin_word_out.sv
module tbin_word_out #(
  parameter int NWIRES = tbin_pkg::TBIN_NWIRES,
  parameter int NBINS  = tbin_pkg::TBIN_NBINS,
  parameter int CNT_W  = tbin_pkg::TBIN_CNT_W,
  parameter int LBINS  = tbin_pkg::TBIN_LEGACY_BINS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    legacy_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CNT_W-1:0]        stop_last_i,
  input  logic [NWIRES*NBINS-1:0] flags_i,
  output logic [NWIRES*NBINS-1:0] word_o,
  output logic                    valid_o
);
  import tbin_pkg::*;

  localparam int OUTW = NWIRES * NBINS;
  localparam int LW   = NWIRES * LBINS;

  logic [OUTW-1:0] full_word, lgc_word, word_d, word_q;
  logic            armed_q, done_q, valid_q;
  logic            close_ev;   // last active bin has just closed

  for (genvar w = 0; w < NWIRES; w++) begin : g_pack
    for (genvar b = 0; b < NBINS; b++) begin : g_full
      assign full_word[f_bitpos(w, b, NBINS)] = flags_i[w*NBINS + b];
    end
    for (genvar b = 0; b < LBINS; b++) begin : g_lgc
      assign lgc_word[f_bitpos(w, b, LBINS)] = flags_i[w*NBINS + b];
    end
  end
  assign lgc_word[OUTW-1:LW] = '0;

  assign word_d   = legacy_i ? lgc_word : full_word;
  assign close_ev = armed_q && !done_q && (cnt_i == stop_last_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (clr_i) begin
      armed_q <= 1'b1;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (close_ev) begin
      done_q  <= 1'b1;
      valid_q <= 1'b1;
      word_q  <= word_d;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R7: valid is a single-cycle pulse
  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R7: valid only follows the cycle at the last active stop
  a_r7_valid_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(cnt_i) == $past(stop_last_i)));

  // R8: upper word bits stay zero in two-bin mode
  a_r8_legacy_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && legacy_i) |-> (word_o[OUTW-1:LW] == '0));

  // R6: the word only changes when a new word is presented
  a_r6_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(word_o));
endmodule

// File: rtl/wire_tbin_encoder.sv
module wire_tbin_encoder #(
  parameter int NWIRES = tbin_pkg::TBIN_NWIRES,
  parameter int NBINS  = tbin_pkg::TBIN_NBINS,
  parameter int CNT_W  = tbin_pkg::TBIN_CNT_W,
  parameter int LBINS  = tbin_pkg::TBIN_LEGACY_BINS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    xing_i,
  input  logic [NWIRES-1:0]       wire_i,
  input  logic                    legacy_i,
  input  logic [NBINS*CNT_W-1:0]  bin_start_i,
  input  logic [NBINS*CNT_W-1:0]  bin_stop_i,
  input  logic [CNT_W-1:0]        nsure_len_i,
  output logic [NWIRES*NBINS-1:0] word_o,
  output logic                    valid_o
);
  localparam int OUTW = NWIRES * NBINS;

  logic [CNT_W-1:0] fine_cnt;
  logic [OUTW-1:0]  all_flags;
  logic             legacy_q;
  logic [CNT_W-1:0] stop_last;

  // mode is captured with the strobe and held for the crossing
  always_ff @(posedge clk) begin
    if (!rst_n)      legacy_q <= 1'b0;
    else if (xing_i) legacy_q <= legacy_i;
  end

  assign stop_last = legacy_q ? bin_stop_i[(LBINS-1)*CNT_W +: CNT_W]
                              : bin_stop_i[(NBINS-1)*CNT_W +: CNT_W];

  tbin_timer #(.CNT_W(CNT_W)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (xing_i),
    .cnt_o (fine_cnt)
  );

  for (genvar w = 0; w < NWIRES; w++) begin : g_wire
    tbin_wire #(.NBINS(NBINS), .CNT_W(CNT_W)) wire_i_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (xing_i),
      .hit_i   (wire_i[w]),
      .cnt_i   (fine_cnt),
      .start_i (bin_start_i),
      .stop_i  (bin_stop_i),
      .nsure_i (nsure_len_i),
      .flags_o (all_flags[w*NBINS +: NBINS])
    );
  end

  tbin_word_out #(.NWIRES(NWIRES), .NBINS(NBINS), .CNT_W(CNT_W),
                  .LBINS(LBINS)) out_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (xing_i),
    .legacy_i    (legacy_q),
    .cnt_i       (fine_cnt),
    .stop_last_i (stop_last),
    .flags_i     (all_flags),
    .word_o      (word_o),
    .valid_o     (valid_o)
  );

  // R1: nothing is presented while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !valid_o);
endmodule

// File: tb/wire_tbin_encoder_tb_top.sv
`timescale 1ns/1ps
module wire_tbin_encoder_tb_top;
  localparam int NW = 12;
  localparam int NB = 6;
  localparam int CW = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             xing = 1'b0;
  logic [NW-1:0]    wires = '0;
  logic             legacy = 1'b0;
  logic [NB*CW-1:0] starts, stops;
  logic [CW-1:0]    nsure = 8'd2;
  logic [NW*NB-1:0] word;
  logic             valid;

  int n_tests = 0;
  int n_fail  = 0;
  int hs[NW];
  int he[NW];
  logic [71:0] got_w;
  logic        got_v, got_pre, got_post;

  always #2.5 clk = ~clk;

  wire_tbin_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .xing_i(xing), .wire_i(wires),
    .legacy_i(legacy), .bin_start_i(starts), .bin_stop_i(stops),
    .nsure_len_i(nsure), .word_o(word), .valid_o(valid)
  );

  task automatic check(input bit ok, input string req,
                       input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_win(input int b, input int s, input int e);
    starts[b*CW +: CW] = CW'(s);
    stops[b*CW +: CW]  = CW'(e);
  endtask

  task automatic default_windows();
    for (int b = 0; b < NB; b++) set_win(b, 4*b, 4*b + 4);
  endtask

  task automatic clear_hits();
    for (int w = 0; w < NW; w++) begin hs[w] = 0; he[w] = 0; end
  endtask

  // one crossing: strobe, then fine counts 0..last with pulses per hs/he
  task automatic crossing(input int last);
    @(negedge clk);
    xing = 1'b1; wires = '0;
    @(posedge clk);
    for (int t = 0; t <= last; t++) begin
      @(negedge clk);
      xing = 1'b0;
      for (int w = 0; w < NW; w++) wires[w] = (t >= hs[w]) && (t < he[w]);
      if (t == last) got_pre = valid;
      @(posedge clk);
    end
    @(negedge clk);
    wires = '0;
    got_v = valid; got_w = word;
    @(negedge clk);
    got_post = valid;
  endtask

  task automatic t_reset();
    check(valid === 1'b0, "R1 valid in reset", 72'(valid), 72'(0));
    check(word === '0, "R1 word in reset", word, 72'(0));
  endtask

  task automatic t_basic();
    logic [71:0] exp = '0;
    clear_hits();
    hs[0] = 1;  he[0] = 3;   exp[0]  = 1'b1;   // bin0
    hs[5] = 13; he[5] = 14;  exp[33] = 1'b1;   // bin3
    hs[11] = 22; he[11] = 23; exp[71] = 1'b1;  // bin5
    crossing(24);
    check(got_pre === 1'b0, "R7 valid low before close", 72'(got_pre), 72'(0));
    check(got_v === 1'b1, "R7 valid after last stop", 72'(got_v), 72'(1));
    check(got_w === exp, "R2 six-bin placement", got_w, exp);
    check(got_post === 1'b0, "R7 single-cycle valid", 72'(got_post), 72'(0));
  endtask

  task automatic t_notsure();
    logic [71:0] exp = '0;
    clear_hits();
    hs[1] = 2; he[1] = 6; exp[6] = 1'b1;                 // bin1 head suppressed
    hs[2] = 2; he[2] = 7; exp[12] = 1'b1; exp[13] = 1'b1; // past head
    hs[4] = 4; he[4] = 5; exp[25] = 1'b1;                 // no prior flag
    nsure = 8'd2;
    crossing(24);
    check(got_w === exp, "R4 not-sure head", got_w, exp);
  endtask

  task automatic t_nsure_zero();
    logic [71:0] exp = '0;
    clear_hits();
    hs[1] = 2; he[1] = 6; exp[6] = 1'b1; exp[7] = 1'b1;
    hs[2] = 2; he[2] = 7; exp[12] = 1'b1; exp[13] = 1'b1;
    hs[4] = 4; he[4] = 5; exp[25] = 1'b1;
    nsure = 8'd0;
    crossing(24);
    check(got_w === exp, "R5 zero head length", got_w, exp);
    nsure = 8'd2;
  endtask

  task automatic t_moved_window();
    logic [71:0] exp = '0;
    clear_hits();
    set_win(2, 9, 11);
    hs[3] = 8;  he[3] = 9;                   // gap between bin1 and bin2: R3
    hs[8] = 11; he[8] = 12;                  // gap after bin2: R3
    hs[10] = 9; he[10] = 10; exp[62] = 1'b1; // moved bin2: R10
    crossing(24);
    check(got_w === exp, "R3/R10 moved window and gaps", got_w, exp);
    check(got_w[3*6 +: 6] === 6'd0, "R3 gap hit ignored", 72'(got_w[3*6 +: 6]), 72'(0));
    default_windows();
  endtask

  task automatic t_clear();
    logic [71:0] exp = '0;
    clear_hits();
    hs[7] = 9; he[7] = 10; exp[44] = 1'b1;
    crossing(24);
    check(got_w === exp, "R6 first crossing", got_w, exp);
    clear_hits();
    crossing(24);
    check(got_w === 72'd0, "R6 no carry-over", got_w, 72'd0);
    check(got_v === 1'b1, "R7 valid every crossing", 72'(got_v), 72'(1));
  endtask

  task automatic t_legacy();
    logic [71:0] exp = '0;
    clear_hits();
    legacy = 1'b1;
    set_win(0, 0, 12);
    set_win(1, 12, 20);
    hs[0] = 3;  he[0] = 4;  exp[0]  = 1'b1;                 // bin0
    hs[6] = 14; he[6] = 15; exp[13] = 1'b1;                 // bin1
    hs[9] = 10; he[9] = 14; exp[18] = 1'b1;                 // R9 suppressed
    hs[3] = 11; he[3] = 15; exp[6] = 1'b1; exp[7] = 1'b1;   // past head
    crossing(20);
    check(got_pre === 1'b0, "R8 valid low before bin1 stop", 72'(got_pre), 72'(0));
    check(got_v === 1'b1, "R8 valid after bin1 stop", 72'(got_v), 72'(1));
    check(got_w === exp, "R8/R9 two-bin packing", got_w, exp);
    check(got_w[71:24] === 48'd0, "R8 upper bits zero", 72'(got_w[71:24]), 72'(0));
    legacy = 1'b0;
    default_windows();
  endtask

  initial begin
    default_windows();
    clear_hits();
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_notsure();
    t_nsure_zero();
    t_moved_window();
    t_clear();
    t_legacy();
    t_basic();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule